// File: doc/BRIEF.md
# Audio serial bit clock divider

This block derives the timing signals of an audio serial link from one kernel clock. A linear divider with a ratio of 2×D+O, where D is an 8-bit value and O a single odd-factor bit, produces a base clock. That base clock either becomes the bit clock directly or becomes a master clock from which a second stage derives the bit clock. The second stage divides by 8 for 16-bit channels and by 4 for 32-bit channels. In both cases the master clock runs at 256 times the frame rate. A word-select signal marks the left and right channel of each frame.

All outputs are level signals in the kernel clock domain, with edges on kernel clock edges. The configuration is captured only while the generator is stopped. Enabling the generator restarts every counter from zero. D values below 2 are replaced by 2, and an error flag reports the replacement. The ratio is then at least 4, which gives sample rates such as 48 kHz or 44.1 kHz from a suitable kernel clock.

Top module: `aud_bclk_gen`

## Requirements
- R1: With the master clock off, the bit clock period is N = 2×D+O kernel cycles, where D is the effective divide value and O the odd bit.
- R2: The base clock is high for D+O cycles and then low for D cycles, so an odd ratio has a high phase one cycle longer than its low phase.
- R3: With the master clock on, the master clock is the base clock. The bit clock has a 50% duty cycle and a period of 8N cycles (16-bit channels) or 4N cycles (32-bit channels), and it rises together with the master clock.
- R4: With the master clock off, the master clock output stays at 0.
- R5: Word select starts low after enable and toggles on every 16th (16-bit) or 32nd (32-bit) falling edge of the bit clock, at the cycle the bit clock goes low. With the master clock on, this gives one frame per 256N cycles.
- R6: A divide value of 0 or 1 is treated as 2, and the error flag is high while such a value is held in the stored configuration. For any other value the flag is low.
- R7: Configuration inputs are sampled only while the generator is stopped. Changes made while it runs do not alter any output.
- R8: While stopped or in reset, all clock outputs are 0. On enable, the counters restart from zero, and the bit clock is high in the first cycle after the enable is registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Generator run enable |
| div_i | input | 8 | Divide value D |
| odd_i | input | 1 | Odd-factor bit O |
| mck_en_i | input | 1 | 1 = produce master clock |
| wide_i | input | 1 | 1 = 32-bit channels, 0 = 16-bit channels |
| mck_o | output | 1 | Master clock |
| bck_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word select, low = left channel |
| div_err_o | output | 1 | Illegal divide value replaced |

## Verification
The assertions assume that `en` and the configuration inputs are synchronous to the kernel clock. They also assume that a change to `en` is registered before the outputs respond. The configuration inputs may change at any time; the assertions check only that the stored copy holds while the generator runs. The stimulus changes every input on the falling clock edge. Random divide values are drawn from 0 to 12, which keeps every frame short and includes the illegal values. A directed case drives the largest divide value, and every run perturbs all configuration inputs right after the enable.

// File: rtl/aud_bclk_gen.sv
module aud_bclk_gen #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [DW-1:0] div_i,
  input  logic          odd_i,
  input  logic          mck_en_i,
  input  logic          wide_i,
  output logic          mck_o,
  output logic          bck_o,
  output logic          ws_o,
  output logic          div_err_o
);
  localparam int CW = DW + 2;

  logic          run;
  logic [DW-1:0] div_q;
  logic          odd_q, mck_q, wide_q;
  logic [DW-1:0] d_eff;
  logic [CW-1:0] cnt, hi_len, ratio;
  logic [2:0]    sub, sub_last;
  logic [4:0]    bits, bits_last;
  logic          bck_q, ws_q;
  logic          lin, lin_end, fall;

  assign div_err_o = div_q < DW'(2);
  assign d_eff     = div_err_o ? DW'(2) : div_q;
  assign ratio     = {1'b0, d_eff, odd_q};
  assign hi_len    = CW'(d_eff) + CW'(odd_q);
  assign lin       = cnt < hi_len;
  assign lin_end   = cnt == ratio - 1'b1;
  assign sub_last  = wide_q ? 3'd1 : 3'd3;
  assign bits_last = wide_q ? 5'd31 : 5'd15;
  assign fall      = mck_q ? (lin_end && sub == sub_last && bck_q)
                           : (cnt == hi_len - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      div_q  <= DW'(2);
      odd_q  <= 1'b0;
      mck_q  <= 1'b0;
      wide_q <= 1'b0;
      cnt    <= '0;
      sub    <= '0;
      bits   <= '0;
      bck_q  <= 1'b1;
      ws_q   <= 1'b0;
    end else begin
      run <= en;
      if (!run) begin
        div_q  <= div_i;
        odd_q  <= odd_i;
        mck_q  <= mck_en_i;
        wide_q <= wide_i;
        cnt    <= '0;
        sub    <= '0;
        bits   <= '0;
        bck_q  <= 1'b1;
        ws_q   <= 1'b0;
      end else begin
        cnt <= lin_end ? '0 : cnt + 1'b1;
        if (mck_q && lin_end) begin
          if (sub == sub_last) begin
            sub   <= '0;
            bck_q <= ~bck_q;
          end else begin
            sub <= sub + 1'b1;
          end
        end
        if (fall) begin
          if (bits == bits_last) begin
            bits <= '0;
            ws_q <= ~ws_q;
          end else begin
            bits <= bits + 1'b1;
          end
        end
      end
    end
  end

  assign mck_o = run & mck_q & lin;
  assign bck_o = run & (mck_q ? bck_q : lin);
  assign ws_o  = run & ws_q;

  assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt < ratio);

  assert_bck_with_mck_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run && $past(run) && mck_q && $rose(bck_o) |-> $rose(mck_o));

  assert_ws_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run && $past(run) && !$stable(ws_o) |-> $fell(bck_o));

  assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run && $past(run) |-> $stable({div_q, odd_q, mck_q, wide_q}));

  assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> cnt == '0 && bck_o && !ws_o);
endmodule

// File: tb/sim_aud_bclk_gen.sv
`timescale 1ns/1ps
module sim_aud_bclk_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [7:0] div_i = 8'd4;
  logic odd_i = 1'b0, mck_en_i = 1'b0, wide_i = 1'b0;
  logic mck_o, bck_o, ws_o, div_err_o;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  aud_bclk_gen u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .div_i(div_i), .odd_i(odd_i),
    .mck_en_i(mck_en_i), .wide_i(wide_i), .mck_o(mck_o), .bck_o(bck_o),
    .ws_o(ws_o), .div_err_o(div_err_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int eff_d(input int d);
    return (d < 2) ? 2 : d;
  endfunction

  task automatic run_cfg(input int d, input bit o, input bit m, input bit w);
    int dd, n, c, p, h, wsx, lat, bfl, brise, mfl, mrise, mones, wsr;
    en = 1'b0;
    repeat (3) @(negedge clk);
    check(!bck_o && !mck_o && !ws_o, "R8 stopped outputs", {bck_o, mck_o, ws_o}, 0);
    div_i = 8'(d); odd_i = o; mck_en_i = m; wide_i = w;
    @(negedge clk);
    en = 1'b1;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!bck_o && lat < 20);
    check(lat == 1, "R8 enable latency", lat, 1);
    dd  = eff_d(d);
    n   = 2 * dd + int'(o);
    c   = w ? 32 : 16;
    p   = m ? n * (w ? 4 : 8) : n;
    h   = m ? p / 2 : dd + int'(o);
    wsx = h + (c - 1) * p;
    check(div_err_o == (d < 2), "R6 error flag", div_err_o, d < 2);
    bfl = -1; brise = -1; mfl = -1; mrise = -1; mones = 0; wsr = -1;
    for (int t = 0; t <= wsx + 1; t++) begin
      if (t > 0) @(negedge clk);
      if (t == 1) begin
        div_i = 8'($urandom_range(0, 255));
        odd_i = ~o; mck_en_i = ~m; wide_i = ~w;
      end
      if (!bck_o && bfl < 0) bfl = t;
      if (bck_o && bfl >= 0 && brise < 0) brise = t;
      if (!mck_o && mfl < 0) mfl = t;
      if (mck_o && mfl >= 0 && mrise < 0) mrise = t;
      if (mck_o) mones++;
      if (ws_o && wsr < 0) wsr = t;
    end
    if (m) begin
      check(bfl == h, "R3 bit clock high phase", bfl, h);
      check(brise == p, "R3 bit clock period", brise, p);
      check(mfl == dd + int'(o), "R2 master clock high phase", mfl, dd + int'(o));
      check(mrise == n, "R7 master clock period after reconfig attempt", mrise, n);
    end else begin
      check(bfl == h, "R2 bit clock high phase", bfl, h);
      check(brise == p, "R1 bit clock period", brise, p);
      check(mones == 0, "R4 master clock idle", mones, 0);
    end
    check(wsr == wsx, "R5 word select first toggle", wsr, wsx);
  endtask

  initial begin
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    check(!bck_o && !mck_o && !ws_o, "R8 reset outputs", {bck_o, mck_o, ws_o}, 0);
    check(!div_err_o, "R6 reset flag", div_err_o, 0);
    rst_n = 1'b1;
    run_cfg(0, 1'b0, 1'b1, 1'b0);
    run_cfg(1, 1'b1, 1'b0, 1'b1);
    run_cfg(2, 1'b0, 1'b1, 1'b1);
    run_cfg(3, 1'b1, 1'b1, 1'b0);
    run_cfg(255, 1'b1, 1'b0, 1'b1);
    run_cfg(7, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 10; i++)
      run_cfg($urandom_range(0, 12), 1'($urandom), 1'($urandom), 1'($urandom));
    en = 1'b0;
    repeat (3) @(negedge clk);
    check(!bck_o && !mck_o && !ws_o, "R8 final stop", {bck_o, mck_o, ws_o}, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule